// File: doc/BRIEF.md
# Row-Stream Read Scheduler

This block orders read transactions for a single DRAM channel. Every accepted read is filed under its bank. Within a bank, reads that target the same row are chained into one stream. A bank can hold a fixed number of streams, and each stream is a small in-order queue. In each cycle the block chooses, for every bank, the one stream that bank would service next. It then grants a single bank and hands the head request of that bank's chosen stream to that bank's command queue.

Within a bank, the block keeps draining the stream that matches the row it last serviced, so that row-buffer hits are exploited. Two guards keep this from starving other reads. The first is a programmable age limit: a stream whose head has waited too long takes precedence. The second is a programmable cap on consecutive same-row services: once the cap is reached, another pending row is forced through. Grants rotate across banks with a round-robin pointer, so that several banks can have work in flight at once.

Top module: `row_stream_sched`

## Requirements
- R1: After reset, req_ready_o is 1 for an idle request and out_valid_o is all zero.
- R2: Reads to the same bank and row share one stream and leave the block in their order of acceptance. Each bank holds at most SLOTS distinct rows at a time.
- R3: req_ready_o is 0 in two cases: (a) the addressed bank has all SLOTS streams holding other rows, or (b) the matching stream already holds DEPTH reads. A read that matches a stream with free room is accepted. The defaults are SLOTS=8 and DEPTH=4.
- R4: Suppose no stream in a bank is over age and the streak cap is not reached. If a stream for the row last dispatched by that bank exists, it is served first. Otherwise the stream with the oldest head read is served.
- R5: Once stk_lim_i consecutive dispatches of a bank have come from one row, the next dispatch of that bank comes from another row if one is pending.
- R6: If the oldest head read in a bank has waited more than age_lim_i cycles since acceptance, its stream is served next, even ahead of a row hit. Age is taken modulo a TS_W-bit cycle counter, with age_lim_i below 2^(TS_W-1).
- R7: At most one bit of out_valid_o is set in a cycle, and only for a bank whose out_ready_i bit is 1. A bank with out_ready_i low dispatches nothing.
- R8: The bank granted last has the lowest priority in the next cycle. With all NB banks pending and ready, any NB consecutive dispatches visit every bank exactly once.
- R9: Every accepted read is dispatched exactly once, with its row, column and id unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| age_lim_i | input | TS_W-1 | Age threshold in cycles |
| stk_lim_i | input | STK_W | Maximum consecutive same-row dispatches per bank |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request accepted this cycle |
| req_bank_i | input | $clog2(NB) | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_id_i | input | ID_W | Requester tag |
| out_ready_i | input | NB | Per-bank command queue can take a request |
| out_valid_o | output | NB | One-hot dispatch strobe to the bank's queue |
| out_row_o | output | ROW_W | Row of dispatched read |
| out_col_o | output | COL_W | Column of dispatched read |
| out_id_o | output | ID_W | Tag of dispatched read |

## Verification
The bench builds the block with four banks, eight streams per bank, four reads per stream and a 10-bit timestamp. With these values a single bank can be filled to its stream limit, and a single stream to its depth, using only a handful of requests. The short timestamp wraps several times during the random run, which exercises the modulo age comparison. The streak cap and the age limit are set to small values for the directed orderings and the random phase, so that both overrides actually fire. The directed orderings test precedence between a row hit, the streak cap and the age override.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    PICK_OLDEST = 2'd0,
    PICK_HIT    = 2'd1,
    PICK_AGED   = 2'd2
  } pick_e;
endpackage

// File: rtl/rss_slot.sv
module rss_slot #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 14,
  parameter int EW    = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             push_i,
  input  logic [EW-1:0]    ent_i,
  input  logic             pop_i,
  output logic             vld_o,
  output logic [ROW_W-1:0] row_o,
  output logic [EW-1:0]    head_o,
  output logic             full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0]    mem_q [DEPTH];
  logic [PW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic             vld_q;
  logic [ROW_W-1:0] row_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
      row_q <= '0;
    end else begin
      if (alloc_i) begin
        vld_q <= 1'b1;
        row_q <= row_i;
      end else if (pop_i && !push_i && cnt_q == CW'(1)) begin
        vld_q <= 1'b0;
      end
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign vld_o  = vld_q;
  assign row_o  = row_q;
  assign head_o = mem_q[rd_q];
  assign full_o = (cnt_q == CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (vld_o && cnt_q != '0));
  assert_alloc_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !vld_o);
endmodule

// File: rtl/rss_bank.sv
module rss_bank
  import rss_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int DEPTH = 4,
  parameter int ROW_W = 14,
  parameter int COL_W = 7,
  parameter int ID_W  = 8,
  parameter int TS_W  = 12,
  parameter int STK_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TS_W-1:0]  now_i,
  input  logic [TS_W-2:0]  age_lim_i,
  input  logic [STK_W-1:0] stk_lim_i,
  input  logic             push_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             pop_i,
  output logic             can_take_o,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [ID_W-1:0]  id_o
);
  localparam int EW = COL_W + ID_W + TS_W;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] s_vld, s_full, s_alloc, s_push, s_pop, s_match, s_open;
  logic [ROW_W-1:0] s_row  [SLOTS];
  logic [EW-1:0]    s_head [SLOTS];
  logic [TS_W-1:0]  s_age  [SLOTS];

  logic [ROW_W-1:0] open_row_q;
  logic             open_vld_q;
  logic [STK_W-1:0] stk_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    rss_slot #(.DEPTH(DEPTH), .ROW_W(ROW_W), .EW(EW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .alloc_i(s_alloc[s]),
      .row_i  (row_i),
      .push_i (s_push[s]),
      .ent_i  ({col_i, id_i, now_i}),
      .pop_i  (s_pop[s]),
      .vld_o  (s_vld[s]),
      .row_o  (s_row[s]),
      .head_o (s_head[s]),
      .full_o (s_full[s])
    );
    assign s_match[s] = s_vld[s] && (s_row[s] == row_i);
    assign s_open[s]  = s_vld[s] && open_vld_q && (s_row[s] == open_row_q);
    assign s_age[s]   = now_i - s_head[s][TS_W-1:0];
  end

  // intake: join matching stream or take lowest free slot
  logic any_match, match_full, any_free;
  always_comb begin
    s_alloc    = '0;
    any_free   = 1'b0;
    any_match  = |s_match;
    match_full = |(s_match & s_full);
    for (int s = 0; s < SLOTS; s++) begin
      if (!s_vld[s] && !any_free) begin
        any_free = 1'b1;
        if (push_i && !any_match) s_alloc[s] = 1'b1;
      end
    end
    s_push = push_i ? ((s_match & {SLOTS{any_match}}) | s_alloc) : '0;
  end
  assign can_take_o = any_match ? !match_full : any_free;

  // selection
  logic          old_any, nh_any, hit_any, aged, capped;
  logic [SW-1:0] old_idx, nh_idx, hit_idx, pick_idx;
  logic [TS_W-1:0] old_age, nh_age;
  pick_e         pick;

  always_comb begin
    old_any = 1'b0; old_idx = '0; old_age = '0;
    nh_any  = 1'b0; nh_idx  = '0; nh_age  = '0;
    hit_idx = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (s_vld[s] && (!old_any || s_age[s] > old_age)) begin
        old_any = 1'b1; old_idx = SW'(s); old_age = s_age[s];
      end
      if (s_vld[s] && !s_open[s] && (!nh_any || s_age[s] > nh_age)) begin
        nh_any = 1'b1; nh_idx = SW'(s); nh_age = s_age[s];
      end
      if (s_open[s]) hit_idx = SW'(s);
    end
    hit_any = |s_open;
    aged    = old_any && (old_age > {1'b0, age_lim_i});
    capped  = (stk_q >= stk_lim_i) && nh_any;
    if (aged) begin
      pick = PICK_AGED;   pick_idx = old_idx;
    end else if (hit_any && !capped) begin
      pick = PICK_HIT;    pick_idx = hit_idx;
    end else begin
      pick = PICK_OLDEST; pick_idx = nh_idx;
    end
    s_pop = '0;
    if (pop_i) s_pop[pick_idx] = 1'b1;
  end

  assign pend_o = |s_vld;
  assign row_o  = s_row[pick_idx];
  assign {col_o, id_o} = s_head[pick_idx][EW-1:TS_W];

  logic was_hit;
  assign was_hit = open_vld_q && (row_o == open_row_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_row_q <= '0;
      open_vld_q <= 1'b0;
      stk_q      <= '0;
    end else if (pop_i) begin
      open_row_q <= row_o;
      open_vld_q <= 1'b1;
      if (!was_hit)           stk_q <= STK_W'(1);
      else if (stk_q != '1)   stk_q <= stk_q + 1'b1;
    end
  end

  assert_age_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && aged) |-> ((now_i - s_head[pick_idx][TS_W-1:0]) > {1'b0, age_lim_i}));
  assert_streak_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !aged && capped) |-> !was_hit);
  assert_hit_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !aged && !capped && hit_any) |-> (row_o == open_row_q));

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      for (int a = 0; a < SLOTS; a++)
        for (int b = a + 1; b < SLOTS; b++)
          assert_unique_rows_R2: assert (!(s_vld[a] && s_vld[b] && s_row[a] == s_row[b]));
    end
  end
endmodule

// File: rtl/rss_rr.sv
module rss_rr #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, gidx;
  logic          found;

  always_comb begin
    gnt_o = '0;
    gidx  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = int'(ptr_q) + i;
      if (k >= N) k = k - N;
      if (!found && req_i[k]) begin
        found    = 1'b1;
        gidx     = IW'(k);
        gnt_o[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (found) ptr_q <= (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
  end

  assert_gnt_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));

  for (genvar b = 0; b < N; b++) begin : g_fair
    assert_rotate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[b] |=> !(gnt_o[b] && ((req_i & ~(N'(1) << b)) != '0)));
  end
endmodule

// File: rtl/row_stream_sched.sv
module row_stream_sched #(
  parameter int NB    = 4,
  parameter int SLOTS = 8,
  parameter int DEPTH = 4,
  parameter int ROW_W = 14,
  parameter int COL_W = 7,
  parameter int ID_W  = 8,
  parameter int TS_W  = 12,
  parameter int STK_W = 4,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TS_W-2:0]  age_lim_i,
  input  logic [STK_W-1:0] stk_lim_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [BW-1:0]    req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic [NB-1:0]    out_ready_i,
  output logic [NB-1:0]    out_valid_o,
  output logic [ROW_W-1:0] out_row_o,
  output logic [COL_W-1:0] out_col_o,
  output logic [ID_W-1:0]  out_id_o
);
  logic [TS_W-1:0]  now_q;
  logic [NB-1:0]    b_take, b_pend, b_push, b_gnt;
  logic [ROW_W-1:0] b_row [NB];
  logic [COL_W-1:0] b_col [NB];
  logic [ID_W-1:0]  b_id  [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  always_comb begin
    req_ready_o = 1'b0;
    for (int b = 0; b < NB; b++)
      if (req_bank_i == BW'(b)) req_ready_o = b_take[b];
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign b_push[b] = req_valid_i && req_ready_o && (req_bank_i == BW'(b));
    rss_bank #(
      .SLOTS(SLOTS), .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W),
      .ID_W(ID_W), .TS_W(TS_W), .STK_W(STK_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .now_i     (now_q),
      .age_lim_i (age_lim_i),
      .stk_lim_i (stk_lim_i),
      .push_i    (b_push[b]),
      .row_i     (req_row_i),
      .col_i     (req_col_i),
      .id_i      (req_id_i),
      .pop_i     (b_gnt[b]),
      .can_take_o(b_take[b]),
      .pend_o    (b_pend[b]),
      .row_o     (b_row[b]),
      .col_o     (b_col[b]),
      .id_o      (b_id[b])
    );
  end

  rss_rr #(.N(NB)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (b_pend & out_ready_i),
    .gnt_o (b_gnt)
  );

  always_comb begin
    out_row_o = '0;
    out_col_o = '0;
    out_id_o  = '0;
    for (int b = 0; b < NB; b++) begin
      if (b_gnt[b]) begin
        out_row_o = b_row[b];
        out_col_o = b_col[b];
        out_id_o  = b_id[b];
      end
    end
  end
  assign out_valid_o = b_gnt;

  assert_one_dispatch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o) && ((out_valid_o & ~out_ready_i) == '0));
  assert_busy_bank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (b_pend != '0));
endmodule

// File: tb/row_stream_sched_bench.sv
`timescale 1ns/1ps
module row_stream_sched_bench;
  localparam int NB = 4, SLOTS = 8, DEPTH = 4, ROW_W = 8, COL_W = 6, ID_W = 8, TS_W = 10, STK_W = 4;
  localparam int LOGN = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TS_W-2:0] age_lim;
  logic [STK_W-1:0] stk_lim;
  logic req_valid, req_ready;
  logic [1:0] req_bank;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [ID_W-1:0] req_id;
  logic [NB-1:0] out_ready, out_valid;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;
  logic [ID_W-1:0] out_id;

  always #4 clk = ~clk;

  row_stream_sched #(.NB(NB), .SLOTS(SLOTS), .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W),
                     .ID_W(ID_W), .TS_W(TS_W), .STK_W(STK_W)) u_row_stream_sched (
    .clk_i(clk), .rst_ni(rst_n), .age_lim_i(age_lim), .stk_lim_i(stk_lim),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col), .req_id_i(req_id),
    .out_ready_i(out_ready), .out_valid_o(out_valid), .out_row_o(out_row),
    .out_col_o(out_col), .out_id_o(out_id));

  int vecs = 0, errs = 0, id_ctr = 0;
  int acc_n = 0, dsp_n = 0;
  int acc_bank [LOGN]; int acc_row [LOGN]; int acc_col [LOGN]; int acc_id [LOGN];
  bit acc_done [LOGN];
  int dsp_bank [LOGN]; int dsp_row [LOGN];
  bit rnd_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: dispatches searched before logging same-edge accepts
  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < NB; b++) begin
        if (out_valid[b]) begin
          int f;
          f = -1;
          for (int j = 0; j < acc_n; j++)
            if (f < 0 && !acc_done[j] && acc_bank[j] == b && acc_row[j] == int'(out_row)) f = j;
          if (f < 0) chk(1'b0, "R9 unknown dispatch row", int'(out_row), -1);
          else begin
            acc_done[f] = 1'b1;
            chk(acc_col[f] == int'(out_col) && acc_id[f] == int'(out_id),
                "R2 per-row order col/id", int'(out_id), acc_id[f]);
          end
          if (dsp_n < LOGN) begin
            dsp_bank[dsp_n] = b; dsp_row[dsp_n] = int'(out_row); dsp_n++;
          end
        end
      end
      if (req_valid && req_ready && acc_n < LOGN) begin
        acc_bank[acc_n] = int'(req_bank); acc_row[acc_n] = int'(req_row);
        acc_col[acc_n] = int'(req_col); acc_id[acc_n] = int'(req_id);
        acc_done[acc_n] = 1'b0; acc_n++;
      end
    end
  end

  function automatic int nth_row(input int b, input int from, input int k);
    int c;
    c = 0;
    for (int i = from; i < dsp_n; i++) begin
      if (dsp_bank[i] == b) begin
        if (c == k) return dsp_row[i];
        c++;
      end
    end
    return -1;
  endfunction

  function automatic int bank_cnt(input int b, input int from);
    int c;
    c = 0;
    for (int i = from; i < dsp_n; i++) if (dsp_bank[i] == b) c++;
    return c;
  endfunction

  task automatic push(input int b, input int r);
    @(posedge clk); #1;
    req_valid = 1'b1; req_bank = 2'(b); req_row = ROW_W'(r);
    req_col = COL_W'($urandom); req_id = ID_W'(id_ctr); id_ctr++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic probe(input int b, input int r, input bit exp, input string req);
    @(posedge clk); #1;
    req_valid = 1'b1; req_bank = 2'(b); req_row = ROW_W'(r);
    #2;
    chk(req_ready == exp, req, int'(req_ready), int'(exp));
    req_valid = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_rows(input int b, input int from, input int r0, input int r1,
                             input int r2, input int r3, input int r4, input string req);
    int e [5];
    e = '{r0, r1, r2, r3, r4};
    for (int k = 0; k < 5; k++)
      if (e[k] >= 0) chk(nth_row(b, from, k) == e[k], req, nth_row(b, from, k), e[k]);
  endtask

  initial begin
    int m, seed;
    seed = $urandom(32'd4242);
    req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0; req_id = '0;
    out_ready = '0; age_lim = 9'd500; stk_lim = 4'd15;
    #20; rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(out_valid == '0, "R1 no dispatch after reset", int'(out_valid), 0);

    // R5 streak cap on bank 0
    cycles(1);
    stk_lim = 4'd2; m = dsp_n;
    push(0, 1); push(0, 2); push(0, 1); push(0, 1); push(0, 1);
    out_ready[0] = 1'b1; cycles(10); out_ready[0] = 1'b0;
    expect_rows(0, m, 1, 1, 2, 1, 1, "R5 streak cap order");

    // R4 row hit first, cap relaxed
    stk_lim = 4'd15; m = dsp_n;
    push(0, 1); push(0, 2); push(0, 1); push(0, 1); push(0, 1);
    out_ready[0] = 1'b1; cycles(10); out_ready[0] = 1'b0;
    expect_rows(0, m, 1, 1, 1, 1, 2, "R4 row hit priority");

    // R6 age override on bank 3
    age_lim = 9'd20;
    out_ready[3] = 1'b1; push(3, 5); cycles(4); out_ready[3] = 1'b0;
    m = dsp_n;
    push(3, 9); cycles(30); push(3, 5);
    out_ready[3] = 1'b1; cycles(6); out_ready[3] = 1'b0;
    expect_rows(3, m, 9, 5, -1, -1, -1, "R6 aged stream beats hit");
    age_lim = 9'd500; m = dsp_n;
    push(3, 9); cycles(30); push(3, 5);
    out_ready[3] = 1'b1; cycles(6); out_ready[3] = 1'b0;
    expect_rows(3, m, 5, 9, -1, -1, -1, "R4 hit wins below age limit");

    // R3 stream slots full on bank 1, R7 blocked bank
    m = dsp_n;
    for (int r = 10; r < 18; r++) push(1, r);
    probe(1, 18, 1'b0, "R3 all slots hold other rows");
    probe(1, 12, 1'b1, "R3 matching stream with room");
    @(negedge clk);
    chk(out_valid[1] == 1'b0, "R7 no dispatch while ready low", int'(out_valid[1]), 0);
    out_ready[1] = 1'b1; cycles(12); out_ready[1] = 1'b0;
    chk(bank_cnt(1, m) == 8, "R9 bank1 drained", bank_cnt(1, m), 8);
    probe(1, 18, 1'b1, "R3 slot freed after drain");

    // R3 stream depth on bank 2
    for (int i = 0; i < DEPTH; i++) push(2, 3);
    probe(2, 3, 1'b0, "R3 stream depth full");
    probe(2, 4, 1'b1, "R3 other row still accepted");
    out_ready[2] = 1'b1; cycles(8); out_ready[2] = 1'b0;

    // R8 rotation across banks
    for (int b = 0; b < NB; b++) begin push(b, 40 + b); push(b, 40 + b); end
    m = dsp_n;
    out_ready = '1; cycles(12);
    chk(dsp_n - m == 8, "R9 rotation batch count", dsp_n - m, 8);
    for (int h = 0; h < 2; h++) begin
      int mask;
      mask = 0;
      for (int i = 0; i < NB; i++) mask = mask | (1 << dsp_bank[m + h * NB + i]);
      chk(mask == 15, "R8 every bank once per round", mask, 15);
    end
    out_ready = '0;

    // random phase
    age_lim = 9'd60; stk_lim = 4'd3;
    fork
      begin
        for (int n = 0; n < 3000; n++) begin
          push(int'($urandom % NB), int'($urandom % 5));
          if ($urandom % 4 == 0) cycles(1);
        end
        rnd_done = 1'b1;
      end
      begin
        while (!rnd_done) begin
          @(posedge clk); #1;
          if (!rnd_done) out_ready = NB'($urandom);
        end
      end
    join
    out_ready = '1; cycles(80);
    chk(acc_n == dsp_n, "R9 all accepted reads dispatched", dsp_n, acc_n);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule